// File: doc/BRIEF.md
# Indirect Register Read Sequencer

This block is a bus master that carries out one indirect register read on a 64-bit register bus. A caller presents a 64-bit translated address and pulses `start`. The block splits that address into a 31-bit direct bus address and an indirect address field. It writes a command word with the read flag set to the direct address. It then reads the same direct address repeatedly, with a fixed interval between reads, until the returned status word shows completion, shows a bus error, or the retry budget runs out.

The outcome is a 2-bit result code plus, on success, the 16-bit data field of the last status word. The register bus is a simple request/response port. A request is held until the slave answers with a one-cycle acknowledge or a one-cycle error. The poll interval is a cycle count parameter, which a bench can shorten. At 200 MHz, 2000 cycles give 10 us. With the default of ten wait steps, the block issues at most eleven reads.

Top module: `indirect_read_seq`

## Requirements
- R1: `start` is accepted only when `busy` is low. `busy` is high from the next cycle until the operation ends. A `start` while `busy` is high has no effect on addresses, data or the number of completions.
- R2: Every bus request, write or read, carries `busAddr` = {1'b0, transAddr[30:0]} of the accepted address.
- R3: The command write data is (transAddr AND 64'h001F_FFFF_0000_0000) with bit 63 set, and all other bits zero.
- R4: The command write completes before any read is issued. A bus error response to the write ends the operation with result 3 (transport error) and no reads.
- R5: In a read response, bit 31 is the done flag, bits [30:28] are the error field and bits [15:0] are the data. A nonzero error field ends the operation at once with result 1 (bus error), whether or not done is set.
- R6: After a read returns neither done nor error, the next read request starts exactly POLL_GAP_CYCLES+1 cycles after the cycle in which that read was acknowledged.
- R7: At most WAIT_STEPS+1 reads are issued. If none returns done, the result is 2 (timeout) and `rdData` is zero.
- R8: When a read returns done with a zero error field, the result is 0 (ok) and `rdData` equals that word's bits [15:0].
- R9: `rdData` is cleared when an operation is accepted. It reads zero while `busy` is high, and it stays zero after any failure.
- R10: A bus error response to any read ends the operation with result 3 (transport error).
- R11: `done` is a one-cycle pulse in the cycle `busy` falls. `result` and `rdData` hold until the next accepted `start`.
- R12: A bus request keeps `busReq`, `busWrite`, `busAddr` and `busWdata` steady until it is acknowledged or errored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an indirect read |
| transAddr | input | 64 | Translated 64-bit address, sampled with `start` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 bus error, 2 timeout, 3 transport error |
| rdData | output | 16 | Returned data, zero unless result is ok |
| busReq | output | 1 | Register bus request |
| busWrite | output | 1 | 1 for the command write, 0 for status reads |
| busAddr | output | 32 | Direct register address |
| busWdata | output | 64 | Command word |
| busAck | input | 1 | Slave acknowledge, one cycle |
| busErr | input | 1 | Slave error response, one cycle |
| busRdata | input | 64 | Read data, valid with `busAck` |

## Verification
The bench sweeps the point at which done first appears across every poll slot, including never. An off-by-one budget would show up as a timeout one read early, or as a twelfth read. It injects a nonzero error field at each slot, both with and without done set. A design that checked done first would return ok instead of a bus error. Transport errors are placed on the write and on early reads, to catch a design that keeps polling. The bench also measures the spacing between reads, since a miscounted gap shifts every later request. A second `start` in mid-operation must not change the address or add a completion.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int WORD_W = 64;
  localparam int BUS_ADDR_W = 32;
  localparam int DATA_W = 16;
  localparam logic [WORD_W-1:0] IND_FIELD_MASK = 64'h001F_FFFF_0000_0000;
  localparam logic [WORD_W-1:0] READ_FLAG = 64'h8000_0000_0000_0000;
  localparam int DONE_BIT = 31;
  localparam int ERR_HI = 30;
  localparam int ERR_LO = 28;

  typedef enum logic [1:0] {
    RES_OK = 2'd0, RES_BUSERR = 2'd1, RES_TIMEOUT = 2'd2, RES_XPORT = 2'd3
  } resCode_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_WRITE, ST_POLL, ST_GAP
  } seqState_t;

  typedef struct packed {
    logic captureAddr;
    logic clearData;
    logic loadData;
  } dpCtrl_t;
endpackage

// File: rtl/isr_datapath.sv
module isr_datapath
  import isr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtrl_t               ctrl,
  input  logic [WORD_W-1:0]     transAddr,
  input  logic [WORD_W-1:0]     busRdata,
  output logic [BUS_ADDR_W-1:0] busAddr,
  output logic [WORD_W-1:0]     busWdata,
  output logic                  stDone,
  output logic                  stErr,
  output logic [DATA_W-1:0]     rdData
);
  logic [WORD_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      if (ctrl.captureAddr) addrQ <= transAddr;
      if (ctrl.clearData) dataQ <= '0;
      else if (ctrl.loadData) dataQ <= busRdata[DATA_W-1:0];
    end
  end

  always_comb begin
    busAddr  = {1'b0, addrQ[BUS_ADDR_W-2:0]};
    busWdata = (addrQ & IND_FIELD_MASK) | READ_FLAG;
    stDone   = busRdata[DONE_BIT];
    stErr    = |busRdata[ERR_HI:ERR_LO];
    rdData   = dataQ;
  end
endmodule

// File: rtl/isr_ctrl.sv
module isr_ctrl
  import isr_pkg::*;
#(
  parameter int POLL_GAP_CYCLES = 2000,
  parameter int WAIT_STEPS = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       busAck,
  input  logic       busErr,
  input  logic       stDone,
  input  logic       stErr,
  output dpCtrl_t    ctrl,
  output logic       busReq,
  output logic       busWrite,
  output logic       busy,
  output logic       done,
  output logic [1:0] result
);
  localparam int MAX_POLLS = WAIT_STEPS + 1;
  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam int GAP_W = $clog2(POLL_GAP_CYCLES + 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(MAX_POLLS - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(POLL_GAP_CYCLES - 1);

  seqState_t state;
  logic [POLL_W-1:0] pollCnt;
  logic [GAP_W-1:0] gapCnt;
  logic goodRead;

  always_comb begin
    busReq   = (state == ST_WRITE) || (state == ST_POLL);
    busWrite = (state == ST_WRITE);
    busy     = (state != ST_IDLE);
    goodRead = (state == ST_POLL) && busAck && !busErr && !stErr && stDone;
    ctrl.captureAddr = (state == ST_IDLE) && start;
    ctrl.clearData   = (state == ST_IDLE) && start;
    ctrl.loadData    = goodRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pollCnt <= '0;
      gapCnt  <= '0;
      done    <= 1'b0;
      result  <= RES_OK;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) state <= ST_WRITE;
        ST_WRITE: begin
          if (busErr) begin
            state <= ST_IDLE; done <= 1'b1; result <= RES_XPORT;
          end else if (busAck) begin
            state <= ST_POLL; pollCnt <= '0;
          end
        end
        ST_POLL: begin
          if (busErr) begin
            state <= ST_IDLE; done <= 1'b1; result <= RES_XPORT;
          end else if (busAck) begin
            if (stErr) begin
              state <= ST_IDLE; done <= 1'b1; result <= RES_BUSERR;
            end else if (stDone) begin
              state <= ST_IDLE; done <= 1'b1; result <= RES_OK;
            end else if (pollCnt == POLL_LAST) begin
              state <= ST_IDLE; done <= 1'b1; result <= RES_TIMEOUT;
            end else begin
              state   <= ST_GAP;
              gapCnt  <= '0;
              pollCnt <= pollCnt + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (gapCnt == GAP_LAST) state <= ST_POLL;
          else gapCnt <= gapCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/indirect_read_seq.sv
module indirect_read_seq
  import isr_pkg::*;
#(
  parameter int POLL_GAP_CYCLES = 2000,
  parameter int WAIT_STEPS = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [63:0] transAddr,
  output logic        busy,
  output logic        done,
  output logic [1:0]  result,
  output logic [15:0] rdData,
  output logic        busReq,
  output logic        busWrite,
  output logic [31:0] busAddr,
  output logic [63:0] busWdata,
  input  logic        busAck,
  input  logic        busErr,
  input  logic [63:0] busRdata
);
  dpCtrl_t ctrl;
  logic stDone;
  logic stErr;

  isr_ctrl #(.POLL_GAP_CYCLES(POLL_GAP_CYCLES), .WAIT_STEPS(WAIT_STEPS)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .busAck(busAck), .busErr(busErr),
    .stDone(stDone), .stErr(stErr), .ctrl(ctrl), .busReq(busReq),
    .busWrite(busWrite), .busy(busy), .done(done), .result(result)
  );

  isr_datapath uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .transAddr(transAddr),
    .busRdata(busRdata), .busAddr(busAddr), .busWdata(busWdata),
    .stDone(stDone), .stErr(stErr), .rdData(rdData)
  );
endmodule

// File: rtl/isr_checker.sv
module isr_checker #(
  parameter int MAX_POLLS = 11
) (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic [1:0]  result,
  input logic [15:0] rdData,
  input logic        busReq,
  input logic        busWrite,
  input logic [31:0] busAddr,
  input logic [63:0] busWdata,
  input logic        busAck,
  input logic        busErr,
  input logic [63:0] busRdata
);
  int readCount;
  logic wrote;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readCount <= 0;
      wrote <= 1'b0;
    end else if (done) begin
      readCount <= 0;
      wrote <= 1'b0;
    end else begin
      if (busReq && !busWrite && (busAck || busErr)) readCount <= readCount + 1;
      if (busReq && busWrite && busAck && !busErr) wrote <= 1'b1;
    end
  end

  assert_addr_bit31_R2: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !busAddr[31]);
  assert_cmd_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite) |-> (busWdata[63] && busWdata[62:53] == '0 && busWdata[31:0] == '0));
  assert_write_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWrite) |-> wrote);
  assert_write_err_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite && busErr) |=> (done && result == 2'd3));
  assert_err_field_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWrite && busAck && !busErr && busRdata[30:28] != 3'd0)
      |=> (done && result == 2'd1));
  assert_poll_budget_R7: assert property (@(posedge clk) disable iff (!rstN)
    readCount <= MAX_POLLS);
  assert_data_zero_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> rdData == 16'd0);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  assert_req_steady_R12: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busReq) && !$past(busAck) && !$past(busErr))
      |-> (busReq && $stable(busWrite) && $stable(busAddr) && $stable(busWdata)));
endmodule

bind indirect_read_seq isr_checker #(.MAX_POLLS(WAIT_STEPS + 1)) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .result(result),
  .rdData(rdData), .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr),
  .busWdata(busWdata), .busAck(busAck), .busErr(busErr), .busRdata(busRdata)
);

// File: tb/indirect_read_seq_test.sv
`timescale 1ns/1ps
module indirect_read_seq_test;
  localparam int GAP = 3;
  localparam int STEPS = 10;
  localparam int MAXP = STEPS + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [63:0] transAddr = '0;
  logic busy, done, busReq, busWrite;
  logic [1:0] result;
  logic [15:0] rdData;
  logic [31:0] busAddr;
  logic [63:0] busWdata;
  logic busAck = 1'b0;
  logic busErr = 1'b0;
  logic [63:0] busRdata = '0;

  indirect_read_seq #(.POLL_GAP_CYCLES(GAP), .WAIT_STEPS(STEPS)) uut (
    .clk(clk), .rstN(rstN), .start(start), .transAddr(transAddr), .busy(busy),
    .done(done), .result(result), .rdData(rdData), .busReq(busReq),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .busErr(busErr), .busRdata(busRdata)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scenario knobs
  int lat = 0, notDone = 0, errAt = -1, errCode = 1, xportAt = -1;
  logic errWithDone = 1'b0;
  logic [63:0] expTrans = '0;
  // observations
  int polls = 0, writes = 0, addrBad = 0, wdataBad = 0, orderBad = 0, gapBad = 0, dones = 0;
  int cnt = 0;
  logic active = 1'b0;
  longint lastStart = 0;
  logic finished = 1'b0;

  function automatic logic [15:0] goodData(input logic [63:0] t, input int k);
    return (t[15:0] ^ 16'h5A5A) + 16'(k);
  endfunction

  always @(negedge clk) begin
    if (done) dones = dones + 1;
    if (busAck || busErr) begin
      busAck = 1'b0; busErr = 1'b0; busRdata = '0; cnt = 0;
    end
    if (busReq) begin
      if (!active) begin
        active = 1'b1; cnt = 0;
        if (!busWrite) begin
          if (writes == 0) orderBad = orderBad + 1;
          if (polls > 0 && (cyc - lastStart) != longint'(lat + 1 + GAP)) gapBad = gapBad + 1;
          lastStart = cyc;
        end
        if (busAddr != {1'b0, expTrans[30:0]}) addrBad = addrBad + 1;
        if (busWrite && busWdata != ((expTrans & 64'h001F_FFFF_0000_0000) | 64'h8000_0000_0000_0000))
          wdataBad = wdataBad + 1;
      end
      if (cnt == lat) begin
        active = 1'b0;
        if (busWrite) begin
          writes = writes + 1;
          if (xportAt == 0) busErr = 1'b1; else busAck = 1'b1;
        end else begin
          if (xportAt == polls + 1) busErr = 1'b1;
          else begin
            busAck = 1'b1;
            busRdata = {12'h0, expTrans[51:32], 1'b0, 3'b0, 4'hF, 8'h0, 16'hFFFF - 16'(polls)};
            if (polls == errAt) begin
              busRdata[30:28] = 3'(errCode);
              busRdata[31] = errWithDone;
            end else if (polls >= notDone) begin
              busRdata[31] = 1'b1;
              busRdata[27:24] = 4'h3;
              busRdata[15:0] = goodData(expTrans, polls);
            end
          end
          polls = polls + 1;
        end
      end else cnt = cnt + 1;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [63:0] t, input logic midStart);
    int expRes, expPolls, waited;
    logic [15:0] expData;
    expTrans = t;
    polls = 0; writes = 0; addrBad = 0; wdataBad = 0; orderBad = 0; gapBad = 0; dones = 0;
    // expected outcome from the requirements
    expRes = 2; expPolls = MAXP; expData = 16'd0;
    if (xportAt == 0) begin expRes = 3; expPolls = 0; end
    else begin
      for (int k = 0; k < MAXP; k++) begin
        if (xportAt == k + 1) begin expRes = 3; expPolls = k + 1; break; end
        if (k == errAt) begin expRes = 1; expPolls = k + 1; break; end
        if (k >= notDone) begin expRes = 0; expPolls = k + 1; expData = goodData(t, k); break; end
      end
    end
    @(negedge clk);
    start = 1'b1; transAddr = t;
    @(negedge clk);
    start = 1'b0; transAddr = ~t;
    chk("R1", "busy after start", busy, 1);
    chk("R9", "rdData cleared at start", rdData, 0);
    waited = 0;
    while (!done && waited < 3000) begin
      if (midStart && waited == 4) start = 1'b1;
      if (midStart && waited == 5) start = 1'b0;
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    chk("R11", "done seen", done, 1);
    chk("R11", "busy low at done", busy, 0);
    chk(expRes == 3 ? (xportAt == 0 ? "R4" : "R10") : expRes == 1 ? "R5" : expRes == 2 ? "R7" : "R8",
        "result", result, expRes);
    chk(expRes == 0 ? "R8" : "R9", "rdData", rdData, expData);
    chk(expRes == 2 ? "R7" : "R5", "read count", polls, expPolls);
    chk("R2", "address errors", addrBad, 0);
    chk("R3", "command word errors", wdataBad, 0);
    chk("R4", "reads before write", orderBad, 0);
    chk("R6", "gap errors", gapBad, 0);
    repeat (3) @(negedge clk);
    chk("R11", "single done pulse", dones, 1);
    chk("R11", "result held", result, expRes);
    chk(midStart ? "R1" : "R12", "write count", writes, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors = errors + 1; checks = checks + 1;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "reset busy", busy, 0);
    chk("R11", "reset done", done, 0);
    chk("R12", "reset busReq", busReq, 0);
    chk("R9", "reset rdData", rdData, 0);
    chk("R11", "reset result", result, 0);
    rstN = 1'b1;
    // R8/R7: done arrives at each slot, or never
    for (int l = 0; l < 3; l++)
      for (int n = 0; n <= MAXP; n++) begin
        lat = l; notDone = n; errAt = -1; xportAt = -1;
        runOp(64'h0123_4567_89AB_CDEF ^ (64'(n) << 36) ^ 64'(l * 97), 1'b0);
      end
    // R5: error field at each slot, with and without done
    for (int e = 0; e < MAXP; e++)
      for (int w = 0; w < 2; w++) begin
        lat = e % 3; notDone = w ? e : 99; errAt = e; errCode = (e % 7) + 1;
        errWithDone = w[0]; xportAt = -1;
        runOp(64'hFEDC_BA98_F654_3210 + 64'(e * 4099), 1'b0);
      end
    // R4/R10: transport errors on write and reads
    for (int x = 0; x < 5; x++) begin
      lat = 1; notDone = 99; errAt = -1; xportAt = x;
      runOp(64'hA5A5_0F0F_FFFF_FFFF - 64'(x), 1'b0);
    end
    // R1: start while busy is ignored
    lat = 2; notDone = 4; errAt = -1; xportAt = -1;
    runOp(64'h7777_1234_8000_4321, 1'b1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule